// File: doc/BRIEF.md
# Dithered Fractional Clock Divider

This block is a single channel of a numerically controlled oscillator. It divides a reference clock by a ratio that need not be an integer. It runs from a clock at twice the reference rate, so one tick of `clk` is half a reference cycle. Each output period has a base length set by a divisor register. A 32-bit phase accumulator adds one extra tick to selected periods, which makes the long-term average ratio exact.

Software programs a divisor, two accumulator increments and an accumulator preset, then sets the enable bit. The coarse part of the period is counted by an 11-bit right-shifting Galois LFSR, not a binary counter. The divisor's coarse field therefore holds an LFSR state, and the coarse count is the number of LFSR steps from that state to the all-ones terminal state. The output `tick_o` is a one-cycle pulse in the last `clk` cycle of each output period.

Top module: `frac_clk_div`

## Requirements
- R1: After synchronous reset the channel is disabled, all configuration registers read as zero internally, and `tick_o` is low.
- R2: While the enable bit (bit 31 of the control word) is 0, `tick_o` stays low. Clearing the bit takes effect from the cycle after the write.
- R3: The coarse field is an 11-bit LFSR state. One LFSR step is: shift right by one, then XOR with 0x500 if the bit shifted out was 1. If N is the number of steps from the programmed state to 0x7FF, the period is 4*(N+3) + F + S cycles of `clk`.
- R4: In the divisor word, bits 1:0 hold the fine count F and bits 12:2 hold the coarse LFSR state. Each unit of F lengthens the period by one cycle.
- R5: S is bit 31 of the accumulator at the start of the period. When it is 1, the period gets one extra cycle.
- R6: At the end of each period the accumulator adds the low increment if its bit 31 is 0, and the high increment if it is 1. This is the only time the accumulator changes while the channel runs.
- R7: A 0-to-1 change of the enable bit loads the preset into the accumulator and starts a fresh period. The first tick arrives L cycles after the cycle in which the enable write is accepted.
- R8: The register word addresses are: 0 control, 1 divisor, 2 low increment, 3 high increment, 4 preset. Writes to addresses 5 to 7 change nothing.
- R9: A divisor write made while the channel is running leaves the period in progress unchanged. The new divisor applies from the next period.
- R10: `tick_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| tick_o | output | 1 | One-cycle pulse in the last cycle of each output period |

## Verification
The assertions assume that the coarse field written before enabling is never zero. A zero state never reaches the terminal state, so the LFSR-liveness property would fail. The bench therefore builds every coarse value by stepping back a chosen number of states from 0x7FF, which always gives a nonzero state. The checks also assume that the divisor and increments are stable for a whole period. The bench only changes them while the channel is disabled, or just after a tick for the deferred-update case.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int ACC_W      = 32;
    localparam int LFSR_W     = 11;
    localparam int FINE_W     = 2;
    localparam int ADDR_W     = 3;
    localparam int SUB_W      = 2;
    localparam int TAIL_BASE  = 12;
    localparam int TAIL_W     = $clog2(TAIL_BASE + (1 << FINE_W) + 1);
    localparam int CTRL_EN_BIT = ACC_W - 1;

    localparam logic [LFSR_W-1:0] LFSR_TAPS = 11'h500;
    localparam logic [LFSR_W-1:0] LFSR_TERM = {LFSR_W{1'b1}};

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_DIV    = 3'd1,
        RA_INC_LO = 3'd2,
        RA_INC_HI = 3'd3,
        RA_PRESET = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              enable;
        logic [LFSR_W-1:0] coarse;
        logic [FINE_W-1:0] fine;
        logic [ACC_W-1:0]  inc_lo;
        logic [ACC_W-1:0]  inc_hi;
        logic [ACC_W-1:0]  preset;
    } cfg_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ACC_W-1:0]  wdata,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                RA_CTRL:   cfg.enable <= wdata[CTRL_EN_BIT];
                RA_DIV: begin
                    cfg.fine   <= wdata[FINE_W-1:0];
                    cfg.coarse <= wdata[FINE_W +: LFSR_W];
                end
                RA_INC_LO: cfg.inc_lo <= wdata;
                RA_INC_HI: cfg.inc_hi <= wdata;
                RA_PRESET: cfg.preset <= wdata;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/fcd_accum.sv
module fcd_accum
    import fcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  logic [ACC_W-1:0] preset,
    input  logic [ACC_W-1:0] inc_lo,
    input  logic [ACC_W-1:0] inc_hi,
    output logic [ACC_W-1:0] acc_q,
    output logic             msb_next
);

    logic [ACC_W-1:0] sum;

    always_comb begin
        sum = acc_q + (acc_q[ACC_W-1] ? inc_hi : inc_lo);
        if (start)
            msb_next = preset[ACC_W-1];
        else if (step)
            msb_next = sum[ACC_W-1];
        else
            msb_next = acc_q[ACC_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (start)
            acc_q <= preset;
        else if (step)
            acc_q <= sum;
    end

    // R6: outside a period end or a restart the accumulator holds
    p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!step && !start) |=> $stable(acc_q));

endmodule

// File: rtl/fcd_period.sv
module fcd_period
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load,
    input  logic [LFSR_W-1:0] coarse,
    input  logic [FINE_W-1:0] fine,
    input  logic              stretch,
    output logic              done
);

    logic [LFSR_W-1:0] lfsr;
    logic [LFSR_W-1:0] lfsr_nx;
    logic [SUB_W-1:0]  sub;
    logic              in_tail;
    logic [TAIL_W-1:0] tail;
    logic [TAIL_W-1:0] len_q;
    logic [TAIL_W-1:0] len_new;

    always_comb begin
        lfsr_nx = lfsr_step(lfsr);
        len_new = TAIL_W'(TAIL_BASE) + TAIL_W'(fine) + TAIL_W'(stretch);
        done    = in_tail && (tail == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr    <= LFSR_TERM;
            sub     <= '0;
            in_tail <= 1'b0;
            tail    <= '0;
            len_q   <= '0;
        end else if (load) begin
            lfsr    <= coarse;
            sub     <= '0;
            len_q   <= len_new;
            in_tail <= (coarse == LFSR_TERM);
            tail    <= len_new - 1'b1;
        end else if (run) begin
            if (!in_tail) begin
                sub <= sub + 1'b1;
                if (sub == '1) begin
                    lfsr <= lfsr_nx;
                    if (lfsr_nx == LFSR_TERM) begin
                        in_tail <= 1'b1;
                        tail    <= len_q - 1'b1;
                    end
                end
            end else if (tail != '0) begin
                tail <= tail - 1'b1;
            end
        end
    end

    // R3: a running LFSR never sits in the dead all-zero state
    p_lfsr_live_r3: assert property (@(posedge clk) disable iff (rst)
        run |-> (lfsr != '0));

    // R5: the tail phase counts down one per cycle until the period ends
    p_tail_count_r5: assert property (@(posedge clk) disable iff (rst)
        (run && !load && in_tail && tail != '0) |=> (in_tail && tail == $past(tail) - 1'b1));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [ACC_W-1:0]  reg_wdata,
    output logic              tick_o
);

    cfg_t             cfg;
    logic             en_d;
    logic             run;
    logic             start;
    logic             done;
    logic             msb_next;
    logic [ACC_W-1:0] acc_q;

    fcd_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) en_d <= 1'b0;
        else     en_d <= cfg.enable;
    end

    always_comb begin
        run    = cfg.enable && en_d;
        start  = cfg.enable && !en_d;
        tick_o = run && done;
    end

    fcd_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .step     (tick_o),
        .preset   (cfg.preset),
        .inc_lo   (cfg.inc_lo),
        .inc_hi   (cfg.inc_hi),
        .acc_q    (acc_q),
        .msb_next (msb_next)
    );

    fcd_period u_period (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .load    (start || tick_o),
        .coarse  (cfg.coarse),
        .fine    (cfg.fine),
        .stretch (msb_next),
        .done    (done)
    );

    // R2: a disabled channel emits nothing
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |-> !tick_o);

    // R10: ticks are single-cycle pulses
    p_tick_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        tick_o;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    frac_clk_div u_frac_clk_div (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .tick_o    (tick_o)
    );

    typedef struct packed {
        logic [11:0] n;
        logic [1:0]  f;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] pre;
        logic [15:0] l1;
        logic [15:0] l2;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{n: 12'd0,   f: 2'd0, lo: 32'h0,         hi: 32'h0,         pre: 32'h0,         l1: 16'd12,  l2: 16'd12},
        '{n: 12'd5,   f: 2'd3, lo: 32'h0,         hi: 32'h0,         pre: 32'h0,         l1: 16'd35,  l2: 16'd35},
        '{n: 12'd0,   f: 2'd1, lo: 32'h4000_0000, hi: 32'hC000_0000, pre: 32'h8000_0000, l1: 16'd14,  l2: 16'd13},
        '{n: 12'd2,   f: 2'd2, lo: 32'h8000_0000, hi: 32'h0,         pre: 32'h0,         l1: 16'd22,  l2: 16'd23},
        '{n: 12'd100, f: 2'd0, lo: 32'h0,         hi: 32'h0,         pre: 32'h8000_0000, l1: 16'd413, l2: 16'd413}
    };

    function automatic logic [10:0] state_before(int n);
        logic [10:0] s;
        s = 11'h7FF;
        for (int i = 0; i < 2047 - n; i++)
            s = {1'b0, s[10:1]} ^ (s[0] ? 11'h500 : 11'h000);
        return s;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_we    = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!tick_o && n < 5000);
    endtask

    task automatic setup(vec_t v);
        wr(3'd0, 32'h0);
        wr(3'd1, {19'b0, state_before(int'(v.n)), v.f});
        wr(3'd2, v.lo);
        wr(3'd3, v.hi);
        wr(3'd4, v.pre);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        int cnt;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tick_o == 1'b0, "R1 tick low in reset", int'(tick_o), 0);
        rst = 1'b0;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tick_o) cnt++;
        end
        chk(cnt == 0, "R1 no tick after reset without enable", cnt, 0);

        // Vector table: R3 R4 R5 R6 R7
        for (int k = 0; k < 5; k++) begin
            setup(VECS[k]);
            wr(3'd0, 32'h8000_0000);
            measure(n);
            chk(n == int'(VECS[k].l1), $sformatf("R7 R3 first period vec%0d", k), n, int'(VECS[k].l1));
            measure(n);
            chk(n == int'(VECS[k].l2), $sformatf("R6 R5 second period vec%0d", k), n, int'(VECS[k].l2));
        end

        // R8: writes to unused addresses change nothing
        setup(VECS[0]);
        wr(3'd0, 32'h8000_0000);
        measure(n);
        wr(3'd5, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0);
        measure(n);
        measure(n);
        chk(n == 12, "R8 period after unused writes", n, 12);

        // R9: divisor change defers to the next period, R10 single pulse
        measure(n);
        wr(3'd1, {19'b0, state_before(1), 2'd0});
        measure(n);
        chk(n == 11, "R9 current period unchanged", n, 11);
        @(negedge clk);
        chk(tick_o == 1'b0, "R10 tick lasts one cycle", int'(tick_o), 0);
        measure(n);
        chk(n == 15, "R9 next period uses new divisor", n, 15);
        measure(n);
        chk(n == 16, "R9 steady new period", n, 16);

        // R2: disabled channel stays quiet
        wr(3'd0, 32'h0);
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tick_o) cnt++;
        end
        chk(cnt == 0, "R2 no ticks while disabled", cnt, 0);

        // R7: re-enable reloads preset (bit 31 now clear)
        setup(VECS[2]);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h8000_0000);
        measure(n);
        chk(n == 13, "R7 preset reload first period", n, 13);
        measure(n);
        chk(n == 13, "R7 R6 second period after low increment", n, 13);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule